// File: doc/BRIEF.md
# Snoop Response Tracker

This block works inside a memory controller on a packet bus that it shares with snooping caches. Every request header the controller accepts goes into a short delay line. The caches answer each request on two wires, owner and shared. These answers arrive a fixed number of cycles after the header cycle, and software sets that number in a 3-bit configuration field.

When an entry reaches the tap selected by that field, the block samples owner and shared in that same cycle and ties them to the request. It then reports three things combinationally for that cycle:

- whether the memory must send a reply;
- the shared bit to place in the reply header;
- the request's tag.

A block read that another cache owns gets no reply from memory. Requests are never reordered, and several of them can be in flight at once, up to one per cycle.

Top module: `snp_resp_tracker`

## Requirements
- R1: The synchronous active-low reset clears every in-flight entry. With delay D, headers presented during reset produce no result, and `rsp_valid` stays low for the first D cycles after reset is released.
- R2: Each header presented with `hdr_valid` high and a known command raises `rsp_valid` for exactly one cycle, D cycles after its header cycle, where D is `cfg_delay` (0 to 7). With D = 0 the result appears in the header cycle itself.
- R3: `rsp_tag` carries the tag of the header being answered. Results come out in header order, including for headers on back-to-back cycles.
- R4: Command codes on `hdr_cmd` are: 0 block read, 1 block write, 2 block flush, 3 single write, 4 conditional single write, 5 I/O read, 6 I/O write, 7 broadcast I/O write, 8 demap. A header with a code from 9 to 15 is not recorded and produces no result.
- R5: For a block read (code 0), if `snp_owner` is high in the result cycle, `rsp_reply_en` is 0.
- R6: For a block read with `snp_owner` low in the result cycle, `rsp_reply_en` is 1, and `rsp_shared` equals `snp_shared` in that cycle.
- R7: For codes 3 and 4, `rsp_reply_en` is 1 whatever the owner wire shows, and `rsp_shared` equals `snp_shared` in the result cycle.
- R8: For codes 1, 2, 5, 6, 7 and 8, `rsp_reply_en` is 1 and `rsp_shared` is 0, whatever the snoop wires show.
- R9: While `rsp_valid` is 0, the outputs `rsp_reply_en`, `rsp_shared` and `rsp_tag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_delay | input | 3 | Cycles from header to snoop sample (held static outside reset) |
| hdr_valid | input | 1 | Header-cycle strobe |
| hdr_cmd | input | 4 | Decoded command code |
| hdr_tag | input | 4 | Request tag carried to the result |
| snp_owner | input | 1 | Owner snoop answer |
| snp_shared | input | 1 | Shared snoop answer |
| rsp_valid | output | 1 | Result pulse for one request |
| rsp_reply_en | output | 1 | Memory must reply |
| rsp_shared | output | 1 | Shared bit for the reply header |
| rsp_tag | output | 4 | Tag of the answered request |

## Verification
Random header streams with random snoop wires are run at delays 0, 1, 3 and 7:

- Delay 0 exercises the combinational bypass.
- Delay 7 exercises the deepest tap.
- Delays 1 and 3 catch a tap index that is off by one.

Dense back-to-back headers with random tags separate correct ordering from dropped or merged entries. Directed sequences cover four further cases:

- A block read whose owner wire changes between its header cycle and its result cycle, which shows that sampling happens at the result cycle only.
- Illegal command codes, which must never produce a result.
- Headers presented during reset, which must never produce a result.
- Snoop wires toggled for the command classes that must ignore them.

// File: rtl/snp_resp_pkg.sv
// Shared command codes and command classes for the snoop response tracker.
package snp_resp_pkg;

    localparam int CMD_W = 4;

    // Bus command codes seen on the header cycle.
    localparam logic [CMD_W-1:0] CMD_RD_BLK  = 4'd0;
    localparam logic [CMD_W-1:0] CMD_WR_BLK  = 4'd1;
    localparam logic [CMD_W-1:0] CMD_FL_BLK  = 4'd2;
    localparam logic [CMD_W-1:0] CMD_WR_SGL  = 4'd3;
    localparam logic [CMD_W-1:0] CMD_CWR_SGL = 4'd4;
    localparam logic [CMD_W-1:0] CMD_IO_RD   = 4'd5;
    localparam logic [CMD_W-1:0] CMD_IO_WR   = 4'd6;
    localparam logic [CMD_W-1:0] CMD_BIO_WR  = 4'd7;
    localparam logic [CMD_W-1:0] CMD_DEMAP   = 4'd8;

    // How a request reacts to the snoop answers.
    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,  // unknown command, not tracked
        CLS_OWNED  = 2'd1,  // reply suppressed by owner, shared copied
        CLS_SHARED = 2'd2,  // always replies, shared copied
        CLS_PLAIN  = 2'd3   // always replies, shared forced low
    } snp_cls_e;

endpackage

// File: rtl/snp_cmd_decode.sv
// Maps a header command code onto its snoop class.
// Assumes: hdr_cmd is meaningful only while hdr_valid is high.
module snp_cmd_decode
    import snp_resp_pkg::*;
(
    input  logic             hdr_valid,
    input  logic [CMD_W-1:0] hdr_cmd,
    output logic             ent_valid,
    output snp_cls_e         ent_cls
);

    // Classify the command; unknown codes yield no entry.
    always_comb begin
        case (hdr_cmd)
            CMD_RD_BLK:                 ent_cls = CLS_OWNED;
            CMD_WR_SGL, CMD_CWR_SGL:    ent_cls = CLS_SHARED;
            CMD_WR_BLK, CMD_FL_BLK,
            CMD_IO_RD,  CMD_IO_WR,
            CMD_BIO_WR, CMD_DEMAP:      ent_cls = CLS_PLAIN;
            default:                    ent_cls = CLS_NONE;
        endcase
        ent_valid = hdr_valid && (ent_cls != CLS_NONE);
    end

endmodule

// File: rtl/snp_delay_line.sv
// One-entry-per-cycle delay line of request records with a selectable tap.
// Tap 0 is the live input; tap k is the entry accepted k cycles earlier.
// Assumes: MAX_DLY >= 2; sel is held static while entries are in flight.
module snp_delay_line
    import snp_resp_pkg::*;
#(
    parameter  int TAG_W   = 4,
    parameter  int MAX_DLY = 7,
    localparam int DLY_W   = $clog2(MAX_DLY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  snp_cls_e         in_cls,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [DLY_W-1:0] sel,
    output logic             out_valid,
    output snp_cls_e         out_cls,
    output logic [TAG_W-1:0] out_tag
);

    logic [MAX_DLY:1]            pv;
    logic [MAX_DLY:1][1:0]       pc;
    logic [MAX_DLY:1][TAG_W-1:0] pt;
    logic [DLY_W-1:0]            tap;

    // Advance every stage by one per cycle; reset empties all stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv <= '0;
            pc <= '0;
            pt <= '0;
        end else begin
            pv[1] <= in_valid;
            pc[1] <= in_valid ? in_cls : CLS_NONE;
            pt[1] <= in_valid ? in_tag : '0;
            for (int k = 2; k <= MAX_DLY; k++) begin
                pv[k] <= pv[k-1];
                pc[k] <= pc[k-1];
                pt[k] <= pt[k-1];
            end
        end
    end

    // Clamp out-of-range tap settings to the deepest stage.
    always_comb begin
        tap = (32'(sel) > MAX_DLY) ? DLY_W'(MAX_DLY) : sel;
    end

    // Select the entry whose snoop answer is due this cycle.
    always_comb begin
        if (tap == '0) begin
            out_valid = in_valid;
            out_cls   = in_valid ? in_cls : CLS_NONE;
            out_tag   = in_valid ? in_tag : '0;
        end else begin
            out_valid = pv[tap];
            out_cls   = snp_cls_e'(pc[tap]);
            out_tag   = pt[tap];
        end
    end

endmodule

// File: rtl/snp_resp_eval.sv
// Combines a due request with the snoop wires sampled this cycle.
// Assumes: owner/shared are valid exactly in the cycle the entry is due.
module snp_resp_eval
    import snp_resp_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             due_valid,
    input  snp_cls_e         due_cls,
    input  logic [TAG_W-1:0] due_tag,
    input  logic             snp_owner,
    input  logic             snp_shared,
    output logic             rsp_valid,
    output logic             rsp_reply_en,
    output logic             rsp_shared,
    output logic [TAG_W-1:0] rsp_tag
);

    // Decide reply and shared bit from the class; all zero when idle.
    always_comb begin
        rsp_valid    = due_valid;
        rsp_reply_en = 1'b0;
        rsp_shared   = 1'b0;
        rsp_tag      = '0;
        if (due_valid) begin
            rsp_tag = due_tag;
            case (due_cls)
                CLS_OWNED: begin
                    rsp_reply_en = !snp_owner;
                    rsp_shared   = snp_shared;
                end
                CLS_SHARED: begin
                    rsp_reply_en = 1'b1;
                    rsp_shared   = snp_shared;
                end
                CLS_PLAIN: begin
                    rsp_reply_en = 1'b1;
                    rsp_shared   = 1'b0;
                end
                default: begin
                    rsp_reply_en = 1'b0;
                    rsp_shared   = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/snp_resp_tracker.sv
// Top of the snoop response tracker: decode, delay line, result evaluation.
// Assumes: cfg_delay changes only while rst_n is low; results are
// combinational in the cycle the snoop answer is sampled.
module snp_resp_tracker
    import snp_resp_pkg::*;
#(
    parameter  int TAG_W   = 4,
    parameter  int MAX_DLY = 7,
    localparam int DLY_W   = $clog2(MAX_DLY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             hdr_valid,
    input  logic [CMD_W-1:0] hdr_cmd,
    input  logic [TAG_W-1:0] hdr_tag,
    input  logic             snp_owner,
    input  logic             snp_shared,
    output logic             rsp_valid,
    output logic             rsp_reply_en,
    output logic             rsp_shared,
    output logic [TAG_W-1:0] rsp_tag
);

    logic             ent_valid;
    snp_cls_e         ent_cls;
    logic             due_valid;
    snp_cls_e         due_cls;
    logic [TAG_W-1:0] due_tag;

    snp_cmd_decode u_dec (
        .hdr_valid (hdr_valid),
        .hdr_cmd   (hdr_cmd),
        .ent_valid (ent_valid),
        .ent_cls   (ent_cls)
    );

    snp_delay_line #(.TAG_W(TAG_W), .MAX_DLY(MAX_DLY)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ent_valid),
        .in_cls    (ent_cls),
        .in_tag    (hdr_tag),
        .sel       (cfg_delay),
        .out_valid (due_valid),
        .out_cls   (due_cls),
        .out_tag   (due_tag)
    );

    snp_resp_eval #(.TAG_W(TAG_W)) u_eval (
        .due_valid    (due_valid),
        .due_cls      (due_cls),
        .due_tag      (due_tag),
        .snp_owner    (snp_owner),
        .snp_shared   (snp_shared),
        .rsp_valid    (rsp_valid),
        .rsp_reply_en (rsp_reply_en),
        .rsp_shared   (rsp_shared),
        .rsp_tag      (rsp_tag)
    );

endmodule

// File: rtl/snp_resp_tracker_chk.sv
// Property checker for the snoop response tracker, bound to the top.
module snp_resp_tracker_chk #(
    parameter int TAG_W = 4,
    parameter int DLY_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DLY_W-1:0] cfg_delay,
    input logic             hdr_valid,
    input logic [3:0]       hdr_cmd,
    input logic [TAG_W-1:0] hdr_tag,
    input logic             snp_owner,
    input logic             snp_shared,
    input logic             rsp_valid,
    input logic             rsp_reply_en,
    input logic             rsp_shared,
    input logic [TAG_W-1:0] rsp_tag
);

    logic [4:0] since_rst;

    // Count cycles since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 5'h1f) since_rst <= since_rst + 5'd1;
    end

    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 5'(cfg_delay)) |-> !rsp_valid);

    p_bypass_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_delay == '0) |-> (rsp_valid == (hdr_valid && hdr_cmd <= 4'd8)));

    p_one_cycle_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_delay == DLY_W'(1) && $past(cfg_delay) == DLY_W'(1) && rsp_valid)
        |-> ($past(hdr_valid) && $past(hdr_tag) == rsp_tag));

    p_bypass_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_delay == '0 && rsp_valid) |-> (rsp_tag == hdr_tag));

    p_illegal_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_delay == '0 && hdr_cmd > 4'd8) |-> !rsp_valid);

    p_no_reply_needs_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_reply_en) |-> snp_owner);

    p_shared_from_wire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_shared |-> (snp_shared && rsp_valid));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_reply_en && !rsp_shared && rsp_tag == '0));

endmodule

bind snp_resp_tracker snp_resp_tracker_chk #(.TAG_W(TAG_W), .DLY_W(DLY_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_delay    (cfg_delay),
    .hdr_valid    (hdr_valid),
    .hdr_cmd      (hdr_cmd),
    .hdr_tag      (hdr_tag),
    .snp_owner    (snp_owner),
    .snp_shared   (snp_shared),
    .rsp_valid    (rsp_valid),
    .rsp_reply_en (rsp_reply_en),
    .rsp_shared   (rsp_shared),
    .rsp_tag      (rsp_tag)
);

// File: tb/snp_resp_tracker_tb.sv
// Self-checking bench: random header streams plus directed corners.
module snp_resp_tracker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TAG_W      = 4;
    localparam int MAX_DLY    = 7;
    localparam int DLY_W      = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DLY_W-1:0] cfg_delay = '0;
    logic             hdr_valid = 1'b0;
    logic [3:0]       hdr_cmd = '0;
    logic [TAG_W-1:0] hdr_tag = '0;
    logic             snp_owner = 1'b0;
    logic             snp_shared = 1'b0;
    logic             rsp_valid;
    logic             rsp_reply_en;
    logic             rsp_shared;
    logic [TAG_W-1:0] rsp_tag;

    snp_resp_tracker #(.TAG_W(TAG_W), .MAX_DLY(MAX_DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_delay(cfg_delay),
        .hdr_valid(hdr_valid), .hdr_cmd(hdr_cmd), .hdr_tag(hdr_tag),
        .snp_owner(snp_owner), .snp_shared(snp_shared),
        .rsp_valid(rsp_valid), .rsp_reply_en(rsp_reply_en),
        .rsp_shared(rsp_shared), .rsp_tag(rsp_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int               n_vec = 0;
    int               n_bad = 0;
    logic             nxt_rst = 1'b0;
    string            force_req = "";
    logic             hv [MAX_DLY];
    logic [3:0]       hc [MAX_DLY];
    logic [TAG_W-1:0] ht [MAX_DLY];

    function automatic logic exp_reply(logic [3:0] c, logic own);
        return !(c == 4'd0 && own);
    endfunction

    function automatic logic exp_shared(logic [3:0] c, logic sh);
        return (c == 4'd0 || c == 4'd3 || c == 4'd4) && sh;
    endfunction

    function automatic string req_reply(logic [3:0] c, logic own);
        if (c == 4'd0) return own ? "R5" : "R6";
        if (c == 4'd3 || c == 4'd4) return "R7";
        return "R8";
    endfunction

    function automatic string req_shared(logic [3:0] c);
        if (c == 4'd0) return "R6";
        if (c == 4'd3 || c == 4'd4) return "R7";
        return "R8";
    endfunction

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle, check outputs mid-cycle, then update history.
    task automatic step(logic v, logic [3:0] c, logic [TAG_W-1:0] t,
                        logic own, logic sh);
        logic             ev;
        logic [3:0]       ec;
        logic [TAG_W-1:0] et;
        logic             src_v;
        int               d;
        @(posedge clk);
        #1;
        rst_n = nxt_rst; hdr_valid = v; hdr_cmd = c; hdr_tag = t;
        snp_owner = own; snp_shared = sh;
        @(negedge clk);
        if (rst_n) begin
            d = int'(cfg_delay);
            if (d == 0) begin src_v = v; ec = c; et = t; end
            else begin src_v = hv[d-1]; ec = hc[d-1]; et = ht[d-1]; end
            ev = src_v && (ec <= 4'd8);
            if (force_req != "")
                check(force_req, int'(rsp_valid), int'(ev));
            else
                check((src_v && ec > 4'd8) ? "R4" : "R2", int'(rsp_valid), int'(ev));
            if (ev) begin
                check("R3", int'(rsp_tag), int'(et));
                check(req_reply(ec, own), int'(rsp_reply_en), int'(exp_reply(ec, own)));
                check(req_shared(ec), int'(rsp_shared), int'(exp_shared(ec, sh)));
            end else begin
                check("R9", int'({rsp_reply_en, rsp_shared, rsp_tag}), 0);
            end
        end
        for (int k = MAX_DLY - 1; k > 0; k--) begin
            hv[k] = rst_n ? hv[k-1] : 1'b0; hc[k] = hc[k-1]; ht[k] = ht[k-1];
        end
        hv[0] = rst_n ? v : 1'b0; hc[0] = c; ht[0] = t;
    endtask

    task automatic do_reset(int d);
        nxt_rst = 1'b0;
        @(posedge clk); #1 cfg_delay = DLY_W'(d);
        step(1'b1, 4'd1, 4'hA, 1'b0, 1'b0);
        step(1'b1, 4'd0, 4'hB, 1'b0, 1'b1);
        nxt_rst = 1'b1;
    endtask

    task automatic rand_run(int cycles);
        for (int i = 0; i < cycles; i++) begin
            logic [3:0] c;
            c = ($urandom % 10 == 0) ? 4'(9 + $urandom % 7) : 4'($urandom % 9);
            step(($urandom % 10) < 7, c, TAG_W'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7411));
        for (int k = 0; k < MAX_DLY; k++) begin hv[k] = 1'b0; hc[k] = '0; ht[k] = '0; end

        // R1: headers during reset must leave nothing in flight.
        do_reset(3);
        force_req = "R1";
        for (int i = 0; i < 3; i++) step(1'b0, 4'd0, 4'h0, 1'b1, 1'b1);
        force_req = "";

        // R5/R6: owner changes between header and sample cycle (delay 3 active).
        step(1'b1, 4'd0, 4'h5, 1'b0, 1'b0);
        step(1'b1, 4'd0, 4'h6, 1'b1, 1'b1);
        step(1'b0, 4'd0, 4'h0, 1'b0, 1'b0);
        step(1'b0, 4'd0, 4'h0, 1'b1, 1'b1);
        step(1'b0, 4'd0, 4'h0, 1'b0, 1'b1);
        // R7/R8: owner and shared toggled for classes that ignore owner.
        step(1'b1, 4'd3, 4'h1, 1'b0, 1'b0);
        step(1'b1, 4'd7, 4'h2, 1'b0, 1'b0);
        step(1'b1, 4'd8, 4'h3, 1'b0, 1'b0);
        step(1'b0, 4'd0, 4'h0, 1'b1, 1'b1);
        step(1'b0, 4'd0, 4'h0, 1'b1, 1'b1);
        step(1'b0, 4'd0, 4'h0, 1'b1, 1'b1);

        // R4: illegal codes at bypass delay.
        do_reset(0);
        for (int c = 9; c < 16; c++) step(1'b1, 4'(c), 4'(c), 1'b0, 1'b1);

        // R2/R3: random streams at several delays.
        rand_run(300);
        do_reset(1);
        rand_run(300);
        do_reset(3);
        rand_run(300);
        do_reset(7);
        for (int i = 0; i < 8; i++) step(1'b1, 4'(i), 4'(i), 1'b1, 1'b1);
        rand_run(300);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule